// File: doc/BRIEF.md
# Manchester Line Decoder with Preamble Gate

This block is the receive front end for a Manchester-coded serial line. It watches the already-synchronised line level once per oversampling tick, which runs at a fixed multiple of the bit rate. It finds the transition in the middle of each bit cell and turns its direction into a data bit. A tick counter measures the time since the last accepted mid-bit transition. The counter is re-centred on every such transition, so slow drift in the sender's bit rate is absorbed one bit at a time. Transitions at cell boundaries are told apart from mid-bit transitions by their timing alone.

Before it passes data on, the decoder can require a run of 1 to 15 bit periods of a selected synchronisation pattern. It signals the end of that run with a one-cycle pulse. Every later bit is then delivered as data with a valid strobe. If a mid-bit transition fails to arrive in time, the decoder raises a one-cycle coding-error pulse and drops its bit lock. The pattern search then starts again from nothing.

Top module: `mdec_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bit_valid`, `bit_data`, `pre_hit` and `code_err` are all 0, and the decoder is not locked.
- R2: A mid-bit transition from high to low yields a default-polarity value of 1, and one from low to high yields 0. With `cfg_pol` = 0 the delivered `bit_data` equals that value. With `cfg_pol` = 1 it is inverted.
- R3: Once locked, a line transition seen 12 to 20 ticks (OVS-OVS/4 to OVS+OVS/4) after the last accepted mid-bit transition is accepted as the next mid-bit transition and restarts the tick count from there. A transition seen earlier than that is a cell-boundary transition and is ignored.
- R4: If a locked decoder sees no transition within 21 ticks of the last accepted one, it pulses `code_err` for one cycle, drops lock, clears any partial or completed pattern match, and delivers nothing for that tick.
- R5: While unlocked, the first line transition is taken as a mid-bit transition. It is decoded and the decoder locks.
- R6: With `cfg_pre_len` = 0 every decoded bit is delivered with `bit_valid` high for one cycle.
- R7: With `cfg_pre_len` = N (1..15), N consecutive decoded values that follow the selected pattern raise `pre_hit` for one cycle in place of a data strobe. Every later decoded bit is delivered as data until the next coding error.
- R8: `cfg_pre_pat` selects the pattern: 0 = every bit 1, 1 = every bit 0, 2 = 0,1,0,1,…, 3 = 1,0,1,0,…. The pattern is compared with the default-polarity value whatever `cfg_pol` is.
- R9: A decoded value that breaks the pattern restarts the match count. The count becomes 1 if that value equals the pattern's first bit, otherwise 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling strobe, OVS per bit period |
| line_in | input | 1 | Synchronised serial line level |
| cfg_pre_len | input | LEN_W | Required pattern run in bit periods; 0 disables the gate |
| cfg_pre_pat | input | 2 | Pattern select (see R8) |
| cfg_pol | input | 1 | Data polarity: 1 inverts delivered bits |
| bit_data | output | 1 | Decoded data bit, valid with `bit_valid` |
| bit_valid | output | 1 | One-cycle strobe for a delivered data bit |
| pre_hit | output | 1 | One-cycle pulse when the required pattern run completes |
| code_err | output | 1 | One-cycle pulse on a missing mid-bit transition |

## Verification
The bench builds the block with its defaults: OVS = 16 and a 4-bit length field. Every length from 0 to 15 is crossed with all four pattern codes, and the polarity alternates between runs. Each run is led by bits that partially match the pattern and then break it, so restarted matching, hits landing inside the lead bits and the first data bit are all reached. The idle gap between runs forces a timeout, which shows that each coding error clears a completed match. Separate runs move a single mid-bit transition to 4 ticks late, 4 ticks early and 5 ticks late. These reach both edges of the acceptance window and the first value outside it.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    typedef enum logic [1:0] {
        PAT_ONES  = 2'd0,
        PAT_ZEROS = 2'd1,
        PAT_ZO    = 2'd2,
        PAT_OZ    = 2'd3
    } pre_pat_e;

    // Receive configuration carried as one bundle
    typedef struct packed {
        logic [3:0] len;
        logic [1:0] pat;
        logic       pol;
    } rx_cfg_t;

    // One decoded mid-bit event from the timing stage
    typedef struct packed {
        logic valid;
        logic raw;   // default-polarity value: 1 = falling mid-bit edge
    } mid_evt_t;

    // Expected pattern value at a position whose parity is idx_odd
    function automatic logic pat_bit(input logic [1:0] pat, input logic idx_odd);
        logic b;
        case (pre_pat_e'(pat))
            PAT_ONES:  b = 1'b1;
            PAT_ZEROS: b = 1'b0;
            PAT_ZO:    b = idx_odd;
            default:   b = ~idx_odd;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/mdec_edge.sv
module mdec_edge (
    input  logic clk,
    input  logic rst,
    input  logic os_tick,
    input  logic line_in,
    output logic edge_seen,
    output logic edge_rise
);
    logic primed;
    logic last_lvl;

    // First tick after reset only loads the level, so an idle line gives no edge
    always_ff @(posedge clk) begin
        if (rst) begin
            primed   <= 1'b0;
            last_lvl <= 1'b0;
        end else if (os_tick) begin
            primed   <= 1'b1;
            last_lvl <= line_in;
        end
    end

    always_comb begin
        edge_seen = os_tick && primed && (line_in != last_lvl);
        edge_rise = line_in;
    end

endmodule

// File: rtl/mdec_timer.sv
module mdec_timer
    import mdec_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     os_tick,
    input  logic     edge_seen,
    input  logic     edge_rise,
    output mid_evt_t mid,
    output logic     err
);
    localparam int WIN_LO = OVS - OVS / 4;
    localparam int WIN_HI = OVS + OVS / 4;
    localparam int CW     = $clog2(WIN_HI + 2);

    logic [CW-1:0] cnt;
    logic [CW-1:0] elapsed;
    logic          locked;

    assign elapsed = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            locked <= 1'b0;
            mid    <= '0;
            err    <= 1'b0;
        end else begin
            mid.valid <= 1'b0;
            err       <= 1'b0;
            if (os_tick) begin
                if (!locked) begin
                    if (edge_seen) begin
                        locked    <= 1'b1;
                        cnt       <= '0;
                        mid.valid <= 1'b1;
                        mid.raw   <= ~edge_rise;
                    end
                end else if (elapsed > CW'(WIN_HI)) begin
                    err    <= 1'b1;
                    locked <= 1'b0;
                    cnt    <= '0;
                end else if (edge_seen && elapsed >= CW'(WIN_LO)) begin
                    cnt       <= '0;
                    mid.valid <= 1'b1;
                    mid.raw   <= ~edge_rise;
                end else begin
                    cnt <= elapsed;
                end
            end
        end
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(WIN_HI));

    p_err_unlocks_r4: assert property (@(posedge clk) disable iff (rst)
        err |-> !locked);

    p_err_no_bit_r4: assert property (@(posedge clk) disable iff (rst)
        !(err && mid.valid));

    p_hunt_locks_r5: assert property (@(posedge clk) disable iff (rst)
        (os_tick && !locked && edge_seen) |=> (mid.valid && locked));

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!locked && !mid.valid && !err));

endmodule

// File: rtl/mdec_pream.sv
module mdec_pream
    import mdec_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] len,
    input  logic [1:0]       pat,
    input  logic             pol,
    input  mid_evt_t         mid,
    input  logic             err,
    output logic             bit_valid,
    output logic             bit_data,
    output logic             pre_hit
);
    localparam int CNT_W = LEN_W + 1;

    logic [LEN_W-1:0] mcnt;
    logic             matched;
    logic             gate_off;
    logic [CNT_W-1:0] next_cnt;
    logic             fits;
    logic             is_first;

    always_comb begin
        gate_off = (len == '0);
        next_cnt = {1'b0, mcnt} + 1'b1;
        fits     = (mid.raw == pat_bit(pat, mcnt[0]));
        is_first = (mid.raw == pat_bit(pat, 1'b0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcnt      <= '0;
            matched   <= 1'b0;
            bit_valid <= 1'b0;
            bit_data  <= 1'b0;
            pre_hit   <= 1'b0;
        end else begin
            bit_valid <= 1'b0;
            pre_hit   <= 1'b0;
            if (err) begin
                matched <= 1'b0;
                mcnt    <= '0;
            end else if (mid.valid) begin
                if (matched || gate_off) begin
                    bit_valid <= 1'b1;
                    bit_data  <= mid.raw ^ pol;
                end else if (fits) begin
                    if (next_cnt == {1'b0, len}) begin
                        pre_hit <= 1'b1;
                        matched <= 1'b1;
                        mcnt    <= '0;
                    end else begin
                        mcnt <= next_cnt[LEN_W-1:0];
                    end
                end else begin
                    mcnt <= is_first ? LEN_W'(1) : '0;
                end
            end
        end
    end

    p_hit_needs_len_r7: assert property (@(posedge clk) disable iff (rst)
        pre_hit |-> (len != '0));

    p_hit_not_data_r7: assert property (@(posedge clk) disable iff (rst)
        !(bit_valid && pre_hit));

    p_data_gated_r6: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> (matched || gate_off));

    p_count_below_len_r9: assert property (@(posedge clk) disable iff (rst)
        (!matched && !gate_off) |-> (mcnt < len));

    p_err_clears_r4: assert property (@(posedge clk) disable iff (rst)
        err |=> (!matched && mcnt == '0 && !bit_valid));

endmodule

// File: rtl/mdec_rx.sv
module mdec_rx
    import mdec_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             os_tick,
    input  logic             line_in,
    input  logic [LEN_W-1:0] cfg_pre_len,
    input  logic [1:0]       cfg_pre_pat,
    input  logic             cfg_pol,
    output logic             bit_data,
    output logic             bit_valid,
    output logic             pre_hit,
    output logic             code_err
);
    logic     edge_seen;
    logic     edge_rise;
    mid_evt_t mid;
    logic     err;

    mdec_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .os_tick   (os_tick),
        .line_in   (line_in),
        .edge_seen (edge_seen),
        .edge_rise (edge_rise)
    );

    mdec_timer #(.OVS(OVS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .os_tick   (os_tick),
        .edge_seen (edge_seen),
        .edge_rise (edge_rise),
        .mid       (mid),
        .err       (err)
    );

    mdec_pream #(.LEN_W(LEN_W)) u_pream (
        .clk       (clk),
        .rst       (rst),
        .len       (cfg_pre_len),
        .pat       (cfg_pre_pat),
        .pol       (cfg_pol),
        .mid       (mid),
        .err       (err),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .pre_hit   (pre_hit)
    );

    assign code_err = err;

    p_err_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(code_err && (bit_valid || pre_hit)));

    p_err_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        code_err |=> !code_err);

    p_reset_outs_r1: assert property (@(posedge clk)
        $past(rst) |-> (!bit_valid && !pre_hit && !code_err && !bit_data));

endmodule

// File: tb/test_mdec_rx.sv
module test_mdec_rx;
    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 16;
    localparam int LEN_W      = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic os_tick = 1'b0;
    logic line_in = 1'b0;
    logic [LEN_W-1:0] cfg_pre_len = '0;
    logic [1:0] cfg_pre_pat = '0;
    logic cfg_pol = 1'b0;
    logic bit_data, bit_valid, pre_hit, code_err;

    int nchk = 0;
    int nfail = 0;

    logic got_bits [0:4095];
    int   got_n = 0;
    int   hit_n = 0;
    int   err_n = 0;
    int   err_pos [0:255];

    logic fr [0:31];
    int   fr_n;
    logic exp_bits [0:31];
    int   exp_n;
    int   exp_hits;

    mdec_rx #(.OVS(OVS), .LEN_W(LEN_W)) i_mdec_rx (
        .clk(clk), .rst(rst), .os_tick(os_tick), .line_in(line_in),
        .cfg_pre_len(cfg_pre_len), .cfg_pre_pat(cfg_pre_pat), .cfg_pol(cfg_pol),
        .bit_data(bit_data), .bit_valid(bit_valid), .pre_hit(pre_hit),
        .code_err(code_err)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            if (bit_valid) begin
                got_bits[got_n % 4096] = bit_data;
                got_n = got_n + 1;
            end
            if (pre_hit) hit_n = hit_n + 1;
            if (code_err) begin
                err_pos[err_n % 256] = got_n;
                err_n = err_n + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            os_tick = 1'b1;
            @(negedge clk);
            os_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    // first_len ticks at the first level, the rest of the cell at the other
    task automatic send_bit(input logic raw, input int first_len);
        line_in = raw;
        tick_n(first_len);
        line_in = ~raw;
        tick_n(OVS - first_len);
    endtask

    task automatic gap(input logic first_raw);
        line_in = first_raw;
        tick_n(3 * OVS);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic pbit(input int pat, input int idx);
        case (pat)
            0: return 1'b1;
            1: return 1'b0;
            2: return idx[0];
            default: return ~idx[0];
        endcase
    endfunction

    // Expected behaviour of the gate, from R6..R9
    task automatic model(input int len, input int pat, input logic pol);
        int  m = 0;
        bit  open = (len == 0);
        exp_n = 0;
        exp_hits = 0;
        for (int i = 0; i < fr_n; i++) begin
            if (open) begin
                exp_bits[exp_n] = fr[i] ^ pol;
                exp_n++;
            end else if (fr[i] == pbit(pat, m)) begin
                m++;
                if (m == len) begin
                    exp_hits++;
                    open = 1;
                    m = 0;
                end
            end else begin
                m = (fr[i] == pbit(pat, 0)) ? 1 : 0;
            end
        end
    endtask

    task automatic compare_run(input int gbase, input int hbase, input string tag);
        chk(got_n - gbase == exp_n, "R6", {tag, " data count"}, got_n - gbase, exp_n);
        chk(hit_n - hbase == exp_hits, "R7", {tag, " hit count"}, hit_n - hbase, exp_hits);
        for (int i = 0; i < exp_n; i++) begin
            if (i < got_n - gbase)
                chk(got_bits[(gbase + i) % 4096] == exp_bits[i], "R2",
                    {tag, " data value"}, int'(got_bits[(gbase + i) % 4096]),
                    int'(exp_bits[i]));
        end
    endtask

    // Skewed run: bit 2 has its first half lasting first_len ticks
    task automatic skew_run(input int first_len, input string tag);
        int gbase;
        int ebase;
        do_reset();
        cfg_pre_len = '0;
        cfg_pre_pat = 2'd0;
        cfg_pol = 1'b0;
        fr_n = 6;
        fr[0] = 1; fr[1] = 1; fr[2] = 0; fr[3] = 1; fr[4] = 0; fr[5] = 0;
        gap(fr[0]);
        gbase = got_n;
        ebase = err_n;
        for (int i = 0; i < fr_n; i++) send_bit(fr[i], (i == 2) ? first_len : OVS / 2);
        tick_n(4);
        if (first_len <= OVS / 2 + OVS / 4) begin
            model(0, 0, 1'b0);
            compare_run(gbase, hit_n, tag);
            chk(err_n == ebase, "R3", {tag, " no error inside window"}, err_n - ebase, 0);
        end else begin
            chk(err_n > ebase, "R4", {tag, " error outside window"}, err_n - ebase, 1);
            if (err_n > ebase)
                chk(err_pos[ebase % 256] - gbase == 2, "R4", {tag, " bits before error"},
                    err_pos[ebase % 256] - gbase, 2);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        bit was_locked = 0;
        int k = 0;
        do_reset();
        @(negedge clk);
        chk(bit_valid == 0 && pre_hit == 0 && code_err == 0 && bit_data == 0, "R1",
            "outputs after reset", int'({bit_valid, pre_hit, code_err, bit_data}), 0);

        for (int pat = 0; pat < 4; pat++) begin
            for (int len = 0; len < 16; len++) begin
                int gbase;
                int hbase;
                int ebase;
                logic [7:0] seed;
                logic pol;
                pol = logic'(len[0] ^ pat[0]);
                seed = 8'(k * 73 + 11);
                fr_n = 0;
                fr[fr_n++] = pbit(pat, 0);
                fr[fr_n++] = ~pbit(pat, 1);
                for (int i = 0; i < len; i++) fr[fr_n++] = pbit(pat, i);
                for (int i = 0; i < 6; i++) fr[fr_n++] = seed[i];

                ebase = err_n;
                gap(fr[0]);
                chk(err_n - ebase == (was_locked ? 1 : 0), "R4", "gap timeout error",
                    err_n - ebase, was_locked ? 1 : 0);

                cfg_pre_len = LEN_W'(len);
                cfg_pre_pat = 2'(pat);
                cfg_pol = pol;
                gbase = got_n;
                hbase = hit_n;
                for (int i = 0; i < fr_n; i++) send_bit(fr[i], OVS / 2);
                tick_n(4);
                model(len, pat, pol);
                compare_run(gbase, hbase, "R5 R8 R9 sweep");
                was_locked = 1;
                k++;
            end
        end

        skew_run(OVS / 2 + OVS / 4, "R3 late edge");
        skew_run(OVS / 2 - OVS / 4, "R3 early edge");
        skew_run(OVS / 2 + OVS / 4 + 1, "R4 beyond window");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule